// File: doc/BRIEF.md
# Dual-Lane Reed-Solomon Syndrome Calculator

This block evaluates a received Reed-Solomon codeword at the 2t consecutive powers of the primitive element alpha. It takes two received symbols on every accepted transfer, so a codeword of n symbols needs about n/2 steps instead of n. Each of the 2t cells is a Horner accumulator that folds one symbol pair per step. The running value is scaled by alpha^(2j), the earlier symbol is scaled by alpha^j, and the later symbol is added unscaled. Every multiplier has a fixed constant, so each one is an XOR network. When n is odd, the first pair carries only one real symbol, and an AND gate forces its early lane to zero.

The symbol pairs arrive on a valid/ready stream. A pair moves when `in_valid` and `in_ready` are both high at a rising clock edge. The producer has to hold a pair until it moves. `in_ready` goes low for exactly one cycle, the cycle in which the result is shown, so that a finished result is never overwritten while it is on display. The first pair of a codeword carries `in_start`. A downstream decoder reads `syn` and `err_present` in the cycle in which `syn_valid` pulses.

Top module: `rs2_syndrome`

## Requirements
- R1: After reset, `syn_valid` is 0, `in_ready` is 1, `syn` is all zero and `err_present` is 0.
- R2: The field is GF(2^5) with the polynomial x^5+x^2+1, and alpha is the element 2. For j = 1..4, S_j = sum over i of r_i * alpha^(j*i), where r_i is the coefficient of x^i. S_j occupies `syn[5j-1:5j-5]`, so S_1 sits in bits [4:0].
- R3: A codeword of 31 symbols arrives as 16 accepted pairs, highest degree first. In each pair, `sym_hi` carries the higher-degree symbol. The first pair carries r30 on `sym_lo`, and its `sym_hi` value is ignored. Pair k (k = 1..15) carries r(31-2k) on `sym_hi` and r(30-2k) on `sym_lo`.
- R4: A pair accepted with `in_start` high clears all accumulators and then folds that pair in as the first pair. A start in the middle of a codeword abandons the earlier codeword, which then produces no result.
- R5: `syn_valid` is high for exactly one cycle, namely the cycle after the edge that accepted the 16th pair. In that cycle `syn` holds the final syndromes, and `syn` does not change in the cycle that follows.
- R6: While `syn_valid` is high, `err_present` is 1 exactly when some syndrome is non-zero. A valid codeword gives 0.
- R7: `in_ready` is 0 during the `syn_valid` cycle, and a pair offered in that cycle is not consumed.
- R8: A pair offered with `in_valid` low, or a pair without `in_start` that arrives outside a codeword, leaves `syn` unchanged and produces no `syn_valid` pulse.
- R9: Idle cycles between the pairs of a codeword do not change the result.
- R10: A new codeword may start in the first cycle after the `syn_valid` cycle, and its result is computed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The producer offers a symbol pair |
| in_ready | output | 1 | The block can consume a pair |
| in_start | input | 1 | Marks the first pair of a codeword |
| sym_hi | input | 5 | Earlier, higher-degree symbol of the pair |
| sym_lo | input | 5 | Later, lower-degree symbol of the pair |
| syn_valid | output | 1 | One-cycle pulse: `syn` is final |
| syn | output | 20 | Packed syndromes S_1..S_4, with S_1 in the low bits |
| err_present | output | 1 | Some syndrome is non-zero |

## Verification
The embedded properties check, on every cycle, the timing and hold behaviour. The result pulse is one cycle wide and always follows an accepted pair. The pair counter stays in its range. A cell holds its value whenever no pair is folded in. The masked first pair loads only the late symbol. The results stay frozen while ready is low. The properties cannot show the arithmetic. Only the bench's codewords can do that, by comparing against a direct single-symbol evaluation. These codewords include all-zero words, valid encoded words, single errors at the two extreme positions, abandoned codewords, idle gaps and stray pairs.

// File: rtl/rs2_syn_pkg.sv
package rs2_syn_pkg;

  // Field multiply by shift-and-reduce, used at elaboration only.
  function automatic int gf_mul(input int a, input int b, input int m, input int poly);
    int r;
    int x;
    r = 0;
    x = a;
    for (int i = 0; i < m; i++) begin
      if (((b >> i) & 1) == 1) r = r ^ x;
      x = x << 1;
      if (((x >> m) & 1) == 1) x = x ^ poly;
    end
    return r;
  endfunction

  // alpha^e with alpha = 2
  function automatic int gf_pow(input int e, input int m, input int poly);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = gf_mul(r, 2, m, poly);
    return r;
  endfunction

endpackage

// File: rtl/gf_const_mul.sv
module gf_const_mul #(
  parameter int M    = 5,
  parameter int POLY = 'h25,
  parameter int K    = 1
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] p
);
  import rs2_syn_pkg::*;

  logic [M-1:0] term [M];

  // Column i is K*alpha^i. Where input bit i is set, that column joins the XOR sum.
  for (genvar i = 0; i < M; i++) begin : g_col
    localparam logic [M-1:0] COLV = M'(gf_mul(K, 1 << i, M, POLY));
    assign term[i] = a[i] ? COLV : '0;
  end

  always_comb begin
    p = '0;
    for (int i = 0; i < M; i++) p = p ^ term[i];
  end
endmodule

// File: rtl/syn_pair_ctrl.sv
module syn_pair_ctrl #(
  parameter int N = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_start,
  output logic in_ready,
  output logic step,
  output logic clear,
  output logic hi_en,
  output logic done
);
  localparam int PAIRS    = (N + 1) / 2;
  localparam bit ODD_LEN  = (N % 2) == 1;
  localparam bit ONE_PAIR = PAIRS == 1;
  localparam int CW       = $clog2(PAIRS + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          acc_ok;
  logic          last;

  assign in_ready = !done;
  assign acc_ok   = in_valid && in_ready;
  assign step     = acc_ok && (in_start || busy);
  assign clear    = acc_ok && in_start;
  // For an odd length the first pair has no early symbol, so its high lane is gated.
  assign hi_en    = !(ODD_LEN && in_start);
  assign last     = step && (in_start ? ONE_PAIR : (cnt == CW'(PAIRS - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (step) begin
        busy <= !last;
        if (last)          cnt <= '0;
        else if (in_start) cnt <= CW'(1);
        else               cnt <= cnt + CW'(1);
      end
    end
  end

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(acc_ok));
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(PAIRS));
endmodule

// File: rtl/syn_pair_cell.sv
module syn_pair_cell #(
  parameter int M        = 5,
  parameter int POLY     = 'h25,
  parameter int ROOT_EXP = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clear,
  input  logic         hi_en,
  input  logic [M-1:0] r_hi,
  input  logic [M-1:0] r_lo,
  output logic [M-1:0] acc
);
  import rs2_syn_pkg::*;

  localparam int K_FB = gf_pow(2 * ROOT_EXP, M, POLY);
  localparam int K_HI = gf_pow(ROOT_EXP, M, POLY);

  logic [M-1:0] base;
  logic [M-1:0] hi_gated;
  logic [M-1:0] fb_prod;
  logic [M-1:0] hi_prod;

  assign base     = clear ? '0 : acc;
  assign hi_gated = r_hi & {M{hi_en}};

  gf_const_mul #(.M(M), .POLY(POLY), .K(K_FB)) u_fb (.a(base),     .p(fb_prod));
  gf_const_mul #(.M(M), .POLY(POLY), .K(K_HI)) u_hi (.a(hi_gated), .p(hi_prod));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (step) acc <= fb_prod ^ hi_prod ^ r_lo;
  end

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(acc));
  p_masked_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && clear && !hi_en) |=> (acc == $past(r_lo)));
endmodule

// File: rtl/rs2_syndrome.sv
module rs2_syndrome #(
  parameter int SYM_W      = 5,
  parameter int FIELD_POLY = 'h25,
  parameter int CW_LEN     = 31,
  parameter int T_CORR     = 2,
  parameter int FIRST_ROOT = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_start,
  input  logic [SYM_W-1:0]            sym_hi,
  input  logic [SYM_W-1:0]            sym_lo,
  output logic                        syn_valid,
  output logic [2*T_CORR*SYM_W-1:0]   syn,
  output logic                        err_present
);
  localparam int NSYN = 2 * T_CORR;

  logic step;
  logic clear;
  logic hi_en;

  syn_pair_ctrl #(.N(CW_LEN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_ready (in_ready),
    .step     (step),
    .clear    (clear),
    .hi_en    (hi_en),
    .done     (syn_valid)
  );

  for (genvar g = 0; g < NSYN; g++) begin : g_cell
    syn_pair_cell #(
      .M        (SYM_W),
      .POLY     (FIELD_POLY),
      .ROOT_EXP (FIRST_ROOT + g)
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .clear (clear),
      .hi_en (hi_en),
      .r_hi  (sym_hi),
      .r_lo  (sym_lo),
      .acc   (syn[g*SYM_W +: SYM_W])
    );
  end

  assign err_present = |syn;

  p_result_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    syn_valid |=> $stable(syn));
  p_ready_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    syn_valid |=> in_ready);
endmodule

// File: tb/rs2_syndrome_tb.sv
`timescale 1ns/1ps
module rs2_syndrome_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_start = 1'b0;
  logic [4:0]  sym_hi = '0;
  logic [4:0]  sym_lo = '0;
  logic        in_ready;
  logic        syn_valid;
  logic [19:0] syn;
  logic        err_present;

  int vecs = 0;
  int errs = 0;

  typedef struct packed { logic [19:0] s; logic e; } exp_t;
  exp_t exp_q[$];
  logic [4:0] cw [31];
  logic [19:0] last_syn;

  always #10 clk = ~clk;

  rs2_syndrome u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .sym_hi(sym_hi), .sym_lo(sym_lo),
    .syn_valid(syn_valid), .syn(syn), .err_present(err_present)
  );

  task automatic chk(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [4:0] mul(input logic [4:0] a, input logic [4:0] b);
    logic [5:0] x;
    logic [4:0] r;
    r = '0;
    x = {1'b0, a};
    for (int i = 0; i < 5; i++) begin
      if (b[i]) r = r ^ x[4:0];
      x = x << 1;
      if (x[5]) x = x ^ 6'h25;
    end
    return r;
  endfunction

  function automatic logic [4:0] apow(input int e);
    logic [4:0] r;
    r = 5'd1;
    for (int i = 0; i < e; i++) r = mul(r, 5'd2);
    return r;
  endfunction

  // Reference: evaluate r(x) at each root symbol by symbol.
  function automatic exp_t reference();
    exp_t x;
    logic [4:0] s;
    x.s = '0;
    for (int j = 1; j <= 4; j++) begin
      s = '0;
      for (int i = 30; i >= 0; i--) s = mul(s, apow(j)) ^ cw[i];
      x.s[5*j-5 +: 5] = s;
    end
    x.e = (x.s != '0);
    return x;
  endfunction

  task automatic send_pair(input logic [4:0] hi, input logic [4:0] lo, input bit st);
    @(negedge clk);
    in_valid = 1'b1; in_start = st; sym_hi = hi; sym_lo = lo;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'($urandom);
      sym_hi = 5'($urandom); sym_lo = 5'($urandom);
    end
  endtask

  // R3 pair order; junk goes on the first pair's high lane.
  task automatic send_frame(input bit gaps, input bit expect_out);
    exp_t x;
    x = reference();
    if (expect_out) exp_q.push_back(x);
    for (int p = 0; p < 16; p++) begin
      if (p == 0) send_pair(5'($urandom), cw[30], 1'b1);
      else        send_pair(cw[31-2*p], cw[30-2*p], 1'b0);
      if (gaps && p < 15 && ($urandom % 3) == 0) idle(1 + ($urandom % 3));
    end
    @(negedge clk);
    chk(syn_valid == 1'b1, "R5 pulse after last pair", 20'(syn_valid), 20'd1);
    last_syn = x.s;
    in_valid = 1'b0; in_start = 1'b0;
  endtask

  task automatic fill_random();
    for (int i = 0; i < 31; i++) cw[i] = 5'($urandom);
  endtask

  task automatic fill_valid();
    logic [4:0] g [5];
    logic [4:0] m [27];
    logic [4:0] rt;
    g[0] = 5'd1; for (int i = 1; i < 5; i++) g[i] = '0;
    for (int j = 1; j <= 4; j++) begin
      rt = apow(j);
      for (int i = 4; i >= 1; i--) g[i] = g[i-1] ^ mul(g[i], rt);
      g[0] = mul(g[0], rt);
    end
    for (int i = 0; i < 27; i++) m[i] = 5'($urandom);
    for (int i = 0; i < 31; i++) cw[i] = '0;
    for (int i = 0; i < 27; i++)
      for (int k = 0; k < 5; k++) cw[i+k] = cw[i+k] ^ mul(m[i], g[k]);
  endtask

  // Scoreboard monitor
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    exp_t x;
    if (rst_n) begin
      if (syn_valid) begin
        chk(!prev_valid, "R5 pulse width", 20'(prev_valid), 20'd0);
        chk(in_ready == 1'b0, "R7 ready low with result", 20'(in_ready), 20'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4/R8 unexpected result", syn, 20'd0);
        end else begin
          x = exp_q.pop_front();
          chk(syn == x.s, "R2 syndromes", syn, x.s);
          chk(err_present == x.e, "R6 error flag", 20'(err_present), 20'(x.e));
        end
      end
      prev_valid <= syn_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; vecs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(syn_valid == 1'b0, "R1 syn_valid", 20'(syn_valid), 20'd0);
    chk(in_ready == 1'b1, "R1 in_ready", 20'(in_ready), 20'd1);
    chk(syn == '0, "R1 syn", syn, 20'd0);
    chk(err_present == 1'b0, "R1 err_present", 20'(err_present), 20'd0);
    rst_n = 1'b1;
    idle(2);

    for (int i = 0; i < 31; i++) cw[i] = '0;
    send_frame(1'b0, 1'b1);                       // R6 all zero
    fill_valid();   send_frame(1'b0, 1'b1);       // R6 valid codeword
    for (int i = 0; i < 31; i++) cw[i] = '0;
    cw[30] = 5'd19; send_frame(1'b0, 1'b1);       // R3 error on top symbol
    cw[30] = '0; cw[0] = 5'd7; send_frame(1'b0, 1'b1); // R2 error at x^0
    fill_random();  send_frame(1'b0, 1'b1);       // R10 back to back
    fill_random();  send_frame(1'b1, 1'b1);       // R9 gaps
    fill_valid();   send_frame(1'b1, 1'b1);       // R9 gaps, valid word

    // R8 stray pair outside a codeword
    idle(2);
    send_pair(5'd31, 5'd9, 1'b0);
    idle(3);
    chk(syn == last_syn, "R8 stray pair ignored", syn, last_syn);
    chk(syn_valid == 1'b0, "R8 no pulse", 20'(syn_valid), 20'd0);

    // R4 abandoned codeword then restart
    fill_random();
    send_pair(cw[29], cw[30], 1'b1);
    for (int p = 1; p < 6; p++) send_pair(cw[31-2*p], cw[30-2*p], 1'b0);
    fill_random();  send_frame(1'b0, 1'b1);

    for (int f = 0; f < 4; f++) begin
      fill_random(); send_frame(f[0], 1'b1);
    end
    idle(4);
    chk(exp_q.size() == 0, "R5 all results seen", 20'(exp_q.size()), 20'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule